// File: doc/BRIEF.md
# Read Strobe Offset Trainer

This engine finds a good read-strobe delay offset for each of the four byte lanes of one memory channel. A one-cycle pulse on `start_i` starts training. The engine first stores a fixed four-word test pattern at the channel's test address through a simple request/response memory port.

For every lane it then searches a signed offset range, first upward from the lower limit and then downward from the upper limit. The two limits come from the coarse DLL lock value on `lock_coarse_i`. At each step the engine reads the four words back and compares only the byte that belongs to the lane under test. The first passing offset from each side is kept. The final offset for each lane is the midpoint of those two points. All four lanes are written into the packed offset output as one word, and `done_o` is raised.

A controller that drives the delay line uses the result. It loads `offset_o` into the delay line on every `resync_o` pulse. After each pulse the engine waits a fixed number of settle cycles before it issues the next read.

Top module: `rdqs_offset_trainer`

States and transitions:
- IDLE → WR_REQ on start.
- WR_REQ → WR_WAIT.
- WR_WAIT → WR_REQ or LANE_INIT on a response. It moves to LANE_INIT after the fourth word.
- LANE_INIT → SYNC.
- STEP_SET → SYNC.
- SYNC → SETTLE.
- SETTLE → the stored return state (STEP_SET, RD_REQ or FINISH) once the settle count is reached.
- RD_REQ → RD_WAIT.
- RD_WAIT → one of three states on a response:
  - RD_REQ when the word matches and more words remain.
  - LANE_NEXT when all four words match, or when the sweep ends.
  - STEP_SET on a mismatch that is not at the end of the sweep.
- LANE_NEXT → LANE_INIT, or CENTER after the downward sweep of lane 3.
- CENTER → SYNC.
- FINISH → IDLE.

## Requirements
- R1: After reset the outputs are as follows:
  - `offset_o` is 0.
  - `done_o`, `busy_o`, `resync_o` and `mem_req_o` are all low.
  - While idle, no request and no resync pulse is issued.
- R2: After a start, the engine issues four writes before any read.
  - The data words, in order, are 0x5A5A5A5A, 0xA5A5A5A5, 0xF0F0F0F0 and 0x0F0F0F0F.
  - Word i goes to address BASE_ADDR + 0x80*chan_i + 4*i.
- R3: The lower sweep limit is 8 − lock. The upper limit is 8 + lock, clamped to at most 127. The value lock is `lock_coarse_i` (0..127), sampled at start.
- R4: The engine handles lanes 0 to 3 with upward sweeps, then lanes 0 to 3 with downward sweeps. Both limits are inclusive and the step is 1.
  - Each sweep stops at the first offset that passes.
  - A sweep with no passing offset yields 8.
- R5: An offset passes only when all four read-back words equal the pattern in the byte of the lane under test. Bits 8n+7..8n belong to lane n. The other bytes are ignored.
- R6: Every lane sweep starts from all four fields set to 0x08. During a sweep only the lane under test changes, so at most one field differs from 0x08 at any read.
- R7: Each lane field uses sign-magnitude encoding.
  - A negative value v is stored as 0x80 | |v|.
  - A value of 0 or more is stored as is.
  - The field value 0x80 never appears.
- R8: Every change of `offset_o` comes with a one-cycle `resync_o` pulse in the same cycle. No read is issued until more than SETTLE_CYC cycles after that pulse.
- R9: At most one memory request is outstanding. A new request is issued only after the previous response has arrived.
- R10: The final value of each lane is the average of its upward and downward results, truncated toward zero and then encoded per R7.
  - The four lanes are written at once and followed by a resync pulse. Then `done_o` rises.
  - `done_o` and `offset_o` hold until the next start.
- R11: A start pulse received while the engine is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| chan_i | input | CH_W | Channel number; selects the test address |
| lock_coarse_i | input | LOCK_W | Coarse DLL lock value |
| mem_req_o | output | 1 | One-cycle memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address of the request |
| mem_wdata_o | output | 32 | Write data |
| mem_rsp_i | input | 1 | Response strobe, one cycle |
| mem_rdata_i | input | 32 | Read data, valid with `mem_rsp_i` |
| offset_o | output | 32 | Packed sign-magnitude lane offsets |
| resync_o | output | 1 | Load-offset pulse for the delay line |
| busy_o | output | 1 | Training in progress |
| done_o | output | 1 | Training finished, held until next start |

## Verification
The hardest case to reach from the ports is a memory that fails in some lanes and not in others, depending on the lane's current offset. This is what makes the lanes' results and midpoints differ from one another.

The bench's memory model therefore decodes `offset_o` at each read. It flips one byte of one word for every lane whose offset lies outside a per-lane window set by the test. The flipped word changes from case to case, so a check that skips any word is caught.

The windows are chosen to cover these situations:
- windows that meet the sweep limits;
- windows that lie entirely at negative offsets;
- empty windows;
- a zero lock value, which gives a single-point sweep;
- the largest lock value, which exercises the clamp.

// File: rtl/rdqs_train_pkg.sv
package rdqs_train_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int DATA_W  = LANES * LANE_W;
    localparam int WORDS   = 4;
    localparam int WIDX_W  = $clog2(WORDS);
    localparam int LIDX_W  = $clog2(LANES);
    localparam int OFF_W   = 10;
    localparam int MAG_W   = LANE_W - 1;
    localparam int DEF_OFF = 8;
    localparam int MAX_OFF = 127;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_LANE_INIT,
        ST_STEP_SET,
        ST_SYNC,
        ST_SETTLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_LANE_NEXT,
        ST_CENTER,
        ST_FINISH
    } trn_state_e;

    // Test word for a given index.
    function automatic logic [DATA_W-1:0] pattern_word(input logic [WIDX_W-1:0] idx);
        logic [DATA_W-1:0] w;
        unique case (idx)
            2'd0:    w = 32'h5A5A_5A5A;
            2'd1:    w = 32'hA5A5_A5A5;
            2'd2:    w = 32'hF0F0_F0F0;
            default: w = 32'h0F0F_0F0F;
        endcase
        return w;
    endfunction

    // Sign-magnitude lane encoding; magnitude assumed <= 127.
    function automatic logic [LANE_W-1:0] sm_encode(input logic signed [OFF_W-1:0] v);
        logic signed [OFF_W-1:0] neg;
        neg = -v;
        if (v < 0)
            return {1'b1, MAG_W'(neg)};
        else
            return LANE_W'(v);
    endfunction

endpackage

// File: rtl/rdqs_limit_calc.sv
module rdqs_limit_calc
    import rdqs_train_pkg::*;
#(
    parameter int LOCK_W = 7
) (
    input  logic [LOCK_W-1:0]       lock_i,
    output logic signed [OFF_W-1:0] left_o,
    output logic signed [OFF_W-1:0] right_o
);

    logic signed [OFF_W-1:0] lock_s;
    logic signed [OFF_W-1:0] upper_raw;

    always_comb begin
        lock_s    = $signed(OFF_W'(lock_i));
        upper_raw = OFF_W'(DEF_OFF) + lock_s;
        left_o    = OFF_W'(DEF_OFF) - lock_s;
        right_o   = (upper_raw > OFF_W'(MAX_OFF)) ? OFF_W'(MAX_OFF) : upper_raw;
    end

endmodule

// File: rtl/rdqs_lane_check.sv
module rdqs_lane_check
    import rdqs_train_pkg::*;
(
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [DATA_W-1:0] expect_i,
    input  logic [LIDX_W-1:0] lane_i,
    output logic              match_o
);

    logic [LANES-1:0] byte_eq;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign byte_eq[g] = (rdata_i[g*LANE_W +: LANE_W] == expect_i[g*LANE_W +: LANE_W]);
    end

    assign match_o = byte_eq[lane_i];

endmodule

// File: rtl/rdqs_center_pack.sv
module rdqs_center_pack
    import rdqs_train_pkg::*;
(
    input  logic [LANES*OFF_W-1:0] left_pk_i,
    input  logic [LANES*OFF_W-1:0] right_pk_i,
    output logic [DATA_W-1:0]      word_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_ctr
        logic signed [OFF_W-1:0] l_s;
        logic signed [OFF_W-1:0] r_s;
        logic signed [OFF_W-1:0] sum_s;
        logic signed [OFF_W-1:0] half_s;

        always_comb begin
            l_s    = $signed(left_pk_i[g*OFF_W +: OFF_W]);
            r_s    = $signed(right_pk_i[g*OFF_W +: OFF_W]);
            sum_s  = l_s + r_s;
            // round toward zero: bias negative sums by one before the shift
            half_s = (sum_s + ((sum_s < 0) ? OFF_W'(1) : OFF_W'(0))) >>> 1;
        end

        assign word_o[g*LANE_W +: LANE_W] = sm_encode(half_s);
    end

endmodule

// File: rtl/rdqs_offset_trainer.sv
module rdqs_offset_trainer
    import rdqs_train_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                CH_W       = 2,
    parameter int                LOCK_W     = 7,
    parameter int                SETTLE_CYC = 4,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic [LOCK_W-1:0] lock_coarse_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_rsp_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] offset_o,
    output logic              resync_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int CNT_W   = $clog2(SETTLE_CYC + 2);
    localparam int CH_SH   = 7;
    localparam int WORD_SH = 2;
    localparam logic [DATA_W-1:0] DEF_WORD = {LANES{LANE_W'(DEF_OFF)}};

    trn_state_e state_q, state_d;
    trn_state_e ret_q;

    logic [WIDX_W-1:0]       word_q;
    logic [LIDX_W-1:0]       lane_q;
    logic                    dir_q;
    logic signed [OFF_W-1:0] cur_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [DATA_W-1:0]       offset_q;
    logic                    done_q;
    logic [LOCK_W-1:0]       lock_q;
    logic [CH_W-1:0]         chan_q;
    logic signed [OFF_W-1:0] lres_q [LANES];
    logic signed [OFF_W-1:0] rres_q [LANES];
    logic                    out_q;

    logic signed [OFF_W-1:0] left_lim, right_lim;
    logic                    lane_match;
    logic [DATA_W-1:0]       center_word;
    logic [LANES*OFF_W-1:0]  lres_pk, rres_pk;
    logic                    at_end;
    logic                    settle_done;
    logic                    last_word;

    rdqs_limit_calc #(.LOCK_W(LOCK_W)) u_limits (
        .lock_i  (lock_q),
        .left_o  (left_lim),
        .right_o (right_lim)
    );

    rdqs_lane_check u_check (
        .rdata_i  (mem_rdata_i),
        .expect_i (pattern_word(word_q)),
        .lane_i   (lane_q),
        .match_o  (lane_match)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_pack
        assign lres_pk[g*OFF_W +: OFF_W] = lres_q[g];
        assign rres_pk[g*OFF_W +: OFF_W] = rres_q[g];
    end

    rdqs_center_pack u_center (
        .left_pk_i  (lres_pk),
        .right_pk_i (rres_pk),
        .word_o     (center_word)
    );

    assign at_end      = (cur_q == (dir_q ? left_lim : right_lim));
    assign settle_done = (cnt_q == CNT_W'(SETTLE_CYC));
    assign last_word   = (word_q == WIDX_W'(WORDS - 1));

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_WR_REQ;
            ST_WR_REQ:    state_d = ST_WR_WAIT;
            ST_WR_WAIT:   if (mem_rsp_i) state_d = last_word ? ST_LANE_INIT : ST_WR_REQ;
            ST_LANE_INIT: state_d = ST_SYNC;
            ST_STEP_SET:  state_d = ST_SYNC;
            ST_SYNC:      state_d = ST_SETTLE;
            ST_SETTLE:    if (settle_done) state_d = ret_q;
            ST_RD_REQ:    state_d = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (mem_rsp_i) begin
                    if (!lane_match)
                        state_d = at_end ? ST_LANE_NEXT : ST_STEP_SET;
                    else if (last_word)
                        state_d = ST_LANE_NEXT;
                    else
                        state_d = ST_RD_REQ;
                end
            end
            ST_LANE_NEXT: state_d = (dir_q && lane_q == LIDX_W'(LANES - 1)) ? ST_CENTER : ST_LANE_INIT;
            ST_CENTER:    state_d = ST_SYNC;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_q    <= ST_IDLE;
            word_q   <= '0;
            lane_q   <= '0;
            dir_q    <= 1'b0;
            cur_q    <= '0;
            cnt_q    <= '0;
            offset_q <= '0;
            done_q   <= 1'b0;
            lock_q   <= '0;
            chan_q   <= '0;
            for (int i = 0; i < LANES; i++) begin
                lres_q[i] <= '0;
                rres_q[i] <= '0;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        done_q <= 1'b0;
                        lock_q <= lock_coarse_i;
                        chan_q <= chan_i;
                        word_q <= '0;
                    end
                end
                ST_WR_WAIT: begin
                    if (mem_rsp_i) begin
                        word_q <= word_q + 1'b1;
                        if (last_word) begin
                            lane_q <= '0;
                            dir_q  <= 1'b0;
                        end
                    end
                end
                ST_LANE_INIT: begin
                    offset_q <= DEF_WORD;
                    if (dir_q) rres_q[lane_q] <= OFF_W'(DEF_OFF);
                    else       lres_q[lane_q] <= OFF_W'(DEF_OFF);
                    cur_q    <= dir_q ? right_lim : left_lim;
                    ret_q    <= ST_STEP_SET;
                end
                ST_STEP_SET: begin
                    offset_q[{lane_q, 3'b000} +: LANE_W] <= sm_encode(cur_q);
                    word_q <= '0;
                    ret_q  <= ST_RD_REQ;
                end
                ST_SYNC:   cnt_q <= '0;
                ST_SETTLE: if (!settle_done) cnt_q <= cnt_q + 1'b1;
                ST_RD_WAIT: begin
                    if (mem_rsp_i) begin
                        if (lane_match) begin
                            word_q <= word_q + 1'b1;
                            if (last_word) begin
                                if (dir_q) rres_q[lane_q] <= cur_q;
                                else       lres_q[lane_q] <= cur_q;
                            end
                        end else if (!at_end) begin
                            cur_q <= dir_q ? (cur_q - OFF_W'(1)) : (cur_q + OFF_W'(1));
                        end
                    end
                end
                ST_LANE_NEXT: begin
                    if (lane_q == LIDX_W'(LANES - 1)) begin
                        lane_q <= '0;
                        dir_q  <= 1'b1;
                    end else begin
                        lane_q <= lane_q + 1'b1;
                    end
                end
                ST_CENTER: begin
                    offset_q <= center_word;
                    ret_q    <= ST_FINISH;
                end
                ST_FINISH: done_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // outstanding-request tracker, used only by the checks below
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         out_q <= 1'b0;
        else if (mem_rsp_i) out_q <= 1'b0;
        else if (mem_req_o) out_q <= 1'b1;
    end

    // outputs
    always_comb begin
        mem_req_o   = (state_q == ST_WR_REQ) || (state_q == ST_RD_REQ);
        mem_we_o    = (state_q == ST_WR_REQ);
        mem_addr_o  = BASE_ADDR
                    + (ADDR_W'(chan_q) << CH_SH)
                    + (ADDR_W'(word_q) << WORD_SH);
        mem_wdata_o = pattern_word(word_q);
        resync_o    = (state_q == ST_SYNC);
        busy_o      = (state_q != ST_IDLE);
        done_o      = done_q;
        offset_o    = offset_q;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !resync_o)); // R1

    AST_RESYNC_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(offset_o) |-> resync_o); // R8

    AST_NO_READ_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        resync_o |=> !mem_req_o); // R8

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !out_q); // R9

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(offset_o))); // R10

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            offset_o[g*LANE_W +: LANE_W] != 8'h80); // R7
    end

endmodule

// File: tb/rdqs_offset_trainer_tb_top.sv
module rdqs_offset_trainer_tb_top;

    localparam int SETTLE = 2;
    localparam logic [31:0] BASE = 32'h4000_0000;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [0:0]  chan_i = '0;
    logic [6:0]  lock_coarse_i = '0;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o;
    logic        mem_rsp_i;
    logic [31:0] mem_rdata_i;
    logic [31:0] offset_o;
    logic        resync_o, busy_o, done_o;

    always #4 clk = ~clk;

    rdqs_offset_trainer #(
        .ADDR_W(32), .CH_W(1), .LOCK_W(7), .SETTLE_CYC(SETTLE), .BASE_ADDR(BASE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .lock_coarse_i(lock_coarse_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rsp_i(mem_rsp_i),
        .mem_rdata_i(mem_rdata_i), .offset_o(offset_o), .resync_o(resync_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    int checks = 0;
    int errors = 0;
    int case_k = 0;
    int win_lo [4];
    int win_hi [4];
    int wr_cnt = 0;
    int since_sync = 100;
    int pend = 0;
    int outstanding = 0;
    logic [31:0] store [4];
    logic [31:0] rd_hold;
    logic [31:0] prev_off = '0;

    function automatic logic [31:0] pat(int i);
        case (i)
            0: return 32'h5A5A5A5A;
            1: return 32'hA5A5A5A5;
            2: return 32'hF0F0F0F0;
            default: return 32'h0F0F0F0F;
        endcase
    endfunction

    function automatic int dec(logic [7:0] b);
        return b[7] ? -int'(b[6:0]) : int'(b[6:0]);
    endfunction

    function automatic logic [7:0] enc(int v);
        return (v < 0) ? (8'h80 | 8'(-v)) : 8'(v);
    endfunction

    function automatic logic [31:0] expected(int lock);
        logic [31:0] w;
        int lft, rgt, l, r;
        lft = 8 - lock;
        rgt = 8 + lock;
        if (rgt > 127) rgt = 127;
        for (int n = 0; n < 4; n++) begin
            l = 8;
            r = 8;
            for (int s = lft; s <= rgt; s++)
                if (s >= win_lo[n] && s <= win_hi[n]) begin l = s; break; end
            for (int s = rgt; s >= lft; s--)
                if (s >= win_lo[n] && s <= win_hi[n]) begin r = s; break; end
            w[n*8 +: 8] = enc((l + r) / 2);
        end
        return w;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s case %0d actual %h expected %h", tag, case_k, act, exp);
        end
    endtask

    // memory model and per-cycle monitors, all at the falling edge
    initial begin
        mem_rsp_i   = 1'b0;
        mem_rdata_i = '0;
        forever begin
            @(negedge clk);
            mem_rsp_i = 1'b0;
            if (rst_n) begin
                if (offset_o != prev_off)
                    chk(resync_o, "R8 resync with offset change", {31'b0, resync_o}, 32'h1);
                prev_off = offset_o;
                since_sync = resync_o ? 0 : since_sync + 1;
                if (pend > 0) begin
                    pend--;
                    if (pend == 0) begin
                        mem_rsp_i   = 1'b1;
                        mem_rdata_i = rd_hold;
                        outstanding = 0;
                    end
                end
                if (mem_req_o) begin
                    chk(outstanding == 0, "R9 single outstanding", outstanding, 0);
                    outstanding = 1;
                    pend = LAT;
                    if (mem_we_o) begin
                        chk(mem_addr_o == BASE + 32'(chan_i) * 128 + 32'(wr_cnt) * 4,
                            "R2 write address", mem_addr_o, BASE + 32'(chan_i) * 128 + 32'(wr_cnt) * 4);
                        chk(mem_wdata_o == pat(wr_cnt), "R2 write data", mem_wdata_o, pat(wr_cnt));
                        store[mem_addr_o[3:2]] = mem_wdata_o;
                        wr_cnt++;
                        rd_hold = '0;
                    end else begin
                        int diff;
                        int idx;
                        chk(wr_cnt >= 4, "R2 writes before reads", wr_cnt, 4);
                        chk(since_sync > SETTLE, "R8 settle before read", since_sync, SETTLE + 1);
                        diff = 0;
                        for (int n = 0; n < 4; n++)
                            if (offset_o[n*8 +: 8] != 8'h08) diff++;
                        chk(diff <= 1, "R6 other lanes at default", offset_o, 32'h08080808);
                        idx = int'(mem_addr_o[3:2]);
                        rd_hold = store[idx];
                        for (int n = 0; n < 4; n++) begin
                            int v;
                            v = dec(offset_o[n*8 +: 8]);
                            if ((v < win_lo[n] || v > win_hi[n]) && idx == (n + case_k) % 4)
                                rd_hold[n*8 +: 8] = rd_hold[n*8 +: 8] ^ 8'hFF;
                        end
                    end
                end
            end
        end
    end

    task automatic setup_case(int k);
        case_k = k;
        case (k)
            0: begin lock_coarse_i = 20; chan_i = 0;
                win_lo = '{0, -5, 10, -20}; win_hi = '{15, 3, 40, -12}; end
            1: begin lock_coarse_i = 0; chan_i = 1;
                win_lo = '{5, 9, -3, 8}; win_hi = '{10, 9, 20, 8}; end
            2: begin lock_coarse_i = 127; chan_i = 0;
                win_lo = '{-119, 100, -3, 1}; win_hi = '{-100, 127, -3, 0}; end
            3: begin lock_coarse_i = 3; chan_i = 1;
                win_lo = '{5, 11, 5, 6}; win_hi = '{11, 11, 5, 9}; end
            default: begin
                lock_coarse_i = 7'((k * 13) % 30);
                chan_i = 1'(k % 2);
                for (int n = 0; n < 4; n++) begin
                    win_lo[n] = ((k * 7 + n * 11) % 30) - 15;
                    win_hi[n] = win_lo[n] + ((k + n) % 9) - 1;
                end
            end
        endcase
    endtask

    task automatic run_case(int k);
        logic [31:0] exp_w;
        int cyc;
        setup_case(k);
        wr_cnt = 0;
        exp_w = expected(int'(lock_coarse_i));
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        chk(busy_o && !done_o, "R10 done cleared on start", {30'b0, busy_o, done_o}, 32'h2);
        cyc = 0;
        while (!done_o && cyc < 60000) begin
            @(negedge clk);
            cyc++;
            if (k == 3 && cyc == 300) begin
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
            end
        end
        chk(offset_o == exp_w, "R3 R4 R5 R7 R10 final offset", offset_o, exp_w);
        chk(wr_cnt == 4, (k == 3) ? "R11 no restart while busy" : "R2 four writes", wr_cnt, 4);
        repeat (15) @(negedge clk);
        chk(done_o && offset_o == exp_w && !busy_o, "R10 result held", offset_o, exp_w);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        win_lo = '{0, 0, 0, 0};
        win_hi = '{0, 0, 0, 0};
        repeat (3) @(negedge clk);
        chk(offset_o == 0 && !done_o && !busy_o && !resync_o && !mem_req_o,
            "R1 reset state", offset_o, 32'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!busy_o && !mem_req_o && !resync_o, "R1 idle quiet", {29'b0, busy_o, mem_req_o, resync_o}, 0);
        for (int k = 0; k < 14; k++) run_case(k);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule